// File: doc/BRIEF.md
# Unsigned Multiplier with 4:2 Compressor Reduction

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It works in three phases. First an AND plane forms one shifted partial-product row per bit of the multiplier operand. Next a tree of 4:2 compressor rows cuts the row count in half at each level until only two rows remain. Last a single carry-propagate adder sums those two rows into the product.

Each compressor cell takes four operand bits and a horizontal carry from the cell one column below it. It returns a column sum, a horizontal carry for the next column and a vertical carry for the next level. The horizontal carry depends only on three of the operand bits and never on the incoming carry, so no carry chain forms along a compressor row. A row of W-bit cells therefore settles in constant depth. With N = 8 there are two compressor levels (8 rows become 4, then 2) and then the final adder, which makes three stages in all. N must be a power of two and at least 4.

The datapath is combinational. A parameter adds an optional output register that is cleared by an active-low asynchronous reset. The block is meant as a drop-in multiply unit for filter taps and other arithmetic paths.

Top module: `mul_ctree`

## Requirements
- R1: With the output register enabled, `prod` equals the exact unsigned product `opa * opb` for every operand pair, taken modulo nothing since the result is 2N bits wide.
- R2: The compressor cell keeps the weight of its inputs: a + b + c + d + cin = sum + 2·(cout + carry) for all 32 input patterns.
- R3: The cell's horizontal carry-out `cout` is the majority of a, b and c and has the same value for cin = 0 and cin = 1.
- R4: The cell's `sum` output is the XOR of all five inputs.
- R5: With the output register enabled, `prod` is 0 while `rst_n` is low whatever the operands, and a new operand pair shows on `prod` one rising clock edge after it is applied, not before.
- R6: With the output register disabled, `prod` follows the operands with no clock edge.
- R7: At the boundaries, an operand of 0 gives 0, an operand of 1 gives the other operand, and all-ones times all-ones gives 2^(2N) − 2^(N+1) + 1 (0xFE01 for N = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset, clears the output register |
| opa | input | N | Multiplicand, unsigned |
| opb | input | N | Multiplier, unsigned; bit i selects partial-product row i |
| prod | output | 2N | Unsigned product |

## Verification
A wrong cell, a miswired horizontal or vertical carry, or a dropped partial-product row changes the product only for operand pairs that set the bits it touches. For that reason every operand pair is applied through the registered variant, and each faulty result shows on `prod` one clock edge after the pair is applied. The compressor cell is also driven alone over all of its input patterns, so a wrong sum or carry equation is seen directly rather than through the tree. The unregistered variant takes random and corner operands and is sampled with no clock edge between applying the operands and reading the result.

// File: rtl/mul_ctree_pkg.sv
package mul_ctree_pkg;

    typedef struct packed {
        logic sum;
        logic cout;
        logic carry;
    } cmp_out_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/cmp42_cell.sv
module cmp42_cell
    import mul_ctree_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    input  logic cin,
    output logic sum,
    output logic cout,
    output logic carry
);
    cmp_out_t res;
    logic     x3;

    always_comb begin
        x3        = a ^ b ^ c;
        res.cout  = maj3(a, b, c);
        res.sum   = x3 ^ d ^ cin;
        res.carry = maj3(x3, d, cin);
    end

    assign sum   = res.sum;
    assign cout  = res.cout;
    assign carry = res.carry;

    // weight of the five inputs equals weight of the three outputs
    always_comb begin
        p_weight_keep_r2: assert ((3'(a) + 3'(b) + 3'(c) + 3'(d) + 3'(cin)) ==
                                  (3'(sum) + 3'(2) * (3'(cout) + 3'(carry))));
    end
endmodule

// File: rtl/cmp42_row.sv
module cmp42_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] s_row,
    output logic [W-1:0] k_row
);
    logic [W-2:0] hcar;
    logic [W-2:0] vcar;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i == W - 1) begin : g_top
            // top column: carries out of the product width are dropped
            assign s_row[i] = r0[i] ^ r1[i] ^ r2[i] ^ r3[i] ^ hcar[i-1];
        end else begin : g_cell
            logic cin_w;
            if (i == 0) begin : g_lsb
                assign cin_w = 1'b0;
            end else begin : g_mid
                assign cin_w = hcar[i-1];
            end
            cmp42_cell u_cell (
                .a     (r0[i]),
                .b     (r1[i]),
                .c     (r2[i]),
                .d     (r3[i]),
                .cin   (cin_w),
                .sum   (s_row[i]),
                .cout  (hcar[i]),
                .carry (vcar[i])
            );
        end
    end

    assign k_row = {vcar, 1'b0};

    // four rows in, two rows out, same total modulo 2^W
    always_comb begin
        p_row_total_r1: assert (W'(s_row + k_row) == W'(r0 + r1 + r2 + r3));
    end
endmodule

// File: rtl/mul_ctree_ppgen.sv
module mul_ctree_ppgen #(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N-1:0]   opa,
    input  logic [N-1:0]   opb,
    output logic [N*W-1:0] pp_flat
);
    for (genvar j = 0; j < N; j++) begin : g_pp
        logic [W-1:0] row_w;
        always_comb begin
            row_w = '0;
            row_w[j +: N] = opa & {N{opb[j]}};
        end
        assign pp_flat[j*W +: W] = row_w;
    end
endmodule

// File: rtl/mul_ctree_tree.sv
module mul_ctree_tree #(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N*W-1:0] pp_flat,
    output logic [W-1:0]   fin_s,
    output logic [W-1:0]   fin_k
);
    localparam int LEVELS = $clog2(N) - 1;
    localparam int NROWS  = 2 * N - 2;

    // rows of every level packed one after another:
    // level l starts at 2N - (2N >> l) and holds N >> l rows
    logic [W-1:0] rows [NROWS];

    for (genvar j = 0; j < N; j++) begin : g_in
        assign rows[j] = pp_flat[j*W +: W];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_OFF  = 2 * N - ((2 * N) >> l);
        localparam int OUT_OFF = 2 * N - ((2 * N) >> (l + 1));
        for (genvar g = 0; g < (N >> (l + 2)); g++) begin : g_grp
            cmp42_row #(.W(W)) u_row (
                .r0    (rows[IN_OFF + 4*g]),
                .r1    (rows[IN_OFF + 4*g + 1]),
                .r2    (rows[IN_OFF + 4*g + 2]),
                .r3    (rows[IN_OFF + 4*g + 3]),
                .s_row (rows[OUT_OFF + 2*g]),
                .k_row (rows[OUT_OFF + 2*g + 1])
            );
        end
    end

    assign fin_s = rows[NROWS - 2];
    assign fin_k = rows[NROWS - 1];
endmodule

// File: rtl/mul_ctree_cpa.sv
module mul_ctree_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    import mul_ctree_pkg::*;

    logic [W-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i] = x[i] ^ y[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = maj3(x[i], y[i], cy[i]);
        end
    end

    always_comb begin
        p_cpa_exact_r1: assert (s == W'(x + y));
    end
endmodule

// File: rtl/mul_ctree.sv
module mul_ctree #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   opa,
    input  logic [N-1:0]   opb,
    output logic [2*N-1:0] prod
);
    localparam int W = 2 * N;

    typedef struct packed {
        logic [W-1:0] prod;
    } out_st_t;

    logic [N*W-1:0] pp_flat;
    logic [W-1:0]   fin_s;
    logic [W-1:0]   fin_k;
    logic [W-1:0]   sum_w;
    out_st_t        st_d;

    mul_ctree_ppgen #(.N(N), .W(W)) u_pp (
        .opa     (opa),
        .opb     (opb),
        .pp_flat (pp_flat)
    );

    mul_ctree_tree #(.N(N), .W(W)) u_tree (
        .pp_flat (pp_flat),
        .fin_s   (fin_s),
        .fin_k   (fin_k)
    );

    mul_ctree_cpa #(.W(W)) u_cpa (
        .x (fin_s),
        .y (fin_k),
        .s (sum_w)
    );

    always_comb begin
        st_d      = '0;
        st_d.prod = sum_w;
    end

    if (OUT_REG) begin : g_reg
        out_st_t st_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign prod = st_q.prod;

        // registered product matches the operands of the previous edge
        p_reg_prod_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod == (W'($past(opa)) * W'($past(opb)))));

        // output stays cleared while reset is held
        always_comb begin
            if (!rst_n) begin
                p_reset_clear_r5: assert (prod == '0);
            end
        end
    end else begin : g_comb
        assign prod = st_d.prod;

        always_comb begin
            p_comb_prod_r6: assert (prod == (W'(opa) * W'(opb)));
        end
    end
endmodule

// File: tb/mul_ctree_test.sv
`timescale 1ns/1ps
module mul_ctree_test;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] opa, opb, ca, cb;
    logic [W-1:0] prod, prod_c;
    logic         ta, tb_, tc, td, tcin;
    logic         tsum, tcout, tcarry;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mul_ctree #(.N(N), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .prod(prod));

    mul_ctree #(.N(N), .OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .opa(ca), .opb(cb), .prod(prod_c));

    cmp42_cell cell_uut (
        .a(ta), .b(tb_), .c(tc), .d(td), .cin(tcin),
        .sum(tsum), .cout(tcout), .carry(tcarry));

    function automatic logic [W-1:0] exp_prod(input logic [N-1:0] x, input logic [N-1:0] y);
        int unsigned r;
        r = 0;
        for (int k = 0; k < N; k++) if (y[k]) r = r + (int'(x) << k);
        return W'(r);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_comb(input logic [N-1:0] x, input logic [N-1:0] y, input string req);
        ca = x; cb = y;
        #1;
        check(prod_c == exp_prod(x, y), req, int'(prod_c), int'(exp_prod(x, y)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pa, pb;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;
        opa = '0; opb = '0; ca = '0; cb = '0;
        {ta, tb_, tc, td, tcin} = '0;
        repeat (3) @(negedge clk);
        check(prod == '0, "R5 reset", int'(prod), 0);
        opa = '1; opb = '1;
        @(negedge clk);
        check(prod == '0, "R5 reset holds", int'(prod), 0);
        rst_n = 1'b1;

        // cell alone, all 32 patterns
        for (int v = 0; v < 32; v++) begin
            int lhs, rhs;
            logic c0;
            {ta, tb_, tc, td, tcin} = 5'(v);
            #1;
            lhs = int'(ta) + int'(tb_) + int'(tc) + int'(td) + int'(tcin);
            rhs = int'(tsum) + 2 * (int'(tcout) + int'(tcarry));
            check(lhs == rhs, "R2 weight", rhs, lhs);
            check(tsum == (ta ^ tb_ ^ tc ^ td ^ tcin), "R4 sum", int'(tsum),
                  int'(ta ^ tb_ ^ tc ^ td ^ tcin));
            check(tcout == ((ta & tb_) | (ta & tc) | (tb_ & tc)), "R3 majority",
                  int'(tcout), int'((ta & tb_) | (ta & tc) | (tb_ & tc)));
            c0 = tcout;
            tcin = ~tcin;
            #1;
            check(tcout == c0, "R3 cin independence", int'(tcout), int'(c0));
        end

        // exhaustive pairs through the registered variant, pipelined
        pa = '0; pb = '0;
        for (int i = 0; i < (1 << (2 * N)); i++) begin
            @(negedge clk);
            if (i > 0)
                check(prod == exp_prod(pa, pb), "R1 exhaustive", int'(prod), int'(exp_prod(pa, pb)));
            {opa, opb} = (2*N)'(i);
            pa = opa; pb = opb;
        end
        @(negedge clk);
        check(prod == exp_prod(pa, pb), "R1 exhaustive last", int'(prod), int'(exp_prod(pa, pb)));

        // one-edge latency: new operands not visible before the edge
        opa = 8'h5A; opb = 8'h3C;
        #1;
        check(prod == exp_prod(pa, pb), "R5 no early update", int'(prod), int'(exp_prod(pa, pb)));
        @(negedge clk);
        check(prod == exp_prod(8'h5A, 8'h3C), "R5 one edge", int'(prod), int'(exp_prod(8'h5A, 8'h3C)));

        // boundaries on registered path
        opa = '1; opb = '1;
        @(negedge clk);
        check(prod == 16'hFE01, "R7 max times max", int'(prod), 16'hFE01);

        // unregistered variant: corners then random
        chk_comb('1, '1, "R7 comb max");
        check(prod_c == 16'hFE01, "R7 comb max value", int'(prod_c), 16'hFE01);
        chk_comb('0, 8'hA7, "R7 comb zero");
        chk_comb(8'hC3, '0, "R7 comb zero b");
        chk_comb(8'd1, 8'hB9, "R7 comb one");
        chk_comb(8'h80, 8'h80, "R7 comb msb");
        for (int r = 0; r < 400; r++) begin
            chk_comb(N'($urandom), N'($urandom), "R6 comb random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule